// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block guards the memory that system-management code lives in. It holds three configuration registers: a primary control byte, an extended control byte and a 16-bit extended-TSEG size word. From these it classifies every memory access, purely combinationally, as going to DRAM, to the PCI/legacy path, or to a blackhole. A blackhole access reads all ones and has its writes discarded.

Three protected regions are decoded. The first is the low legacy window at `LEG_BASE` (default 0xA0000, 128 KiB). The second is a high alias of that window at 0xFEDA0000, which reaches the same DRAM bytes. The third is a TSEG region that ends at the top of low memory (`LOW_TOP`). The outcome depends on whether the access is flagged as system-management mode (SMM). It also depends on the open, global-enable and high-enable bits, and on a one-way lock. Once the lock is set, the open bit is closed and both control bytes are frozen.

Route codes: 0 = DRAM, 1 = PCI path, 2 = blackhole.

Top module: `smm_route_ctrl`

## Requirements
- R1: After reset the primary control byte reads 0x00, the extended control byte reads 0x00 and the TSEG size word reads 0xFFFF, which is the query value.
- R2: Register writes use a 2-bit select:
  - Select 0 writes the primary byte. Only bits [2:0] are writable: bit 0 open, bit 1 lock, bit 2 global enable.
  - Select 1 writes the extended byte. Only bits [3:0] are writable: bit 0 TSEG enable, bits [2:1] size code, bit 3 high enable.
  - Select 2 writes the size word.
  - Bits outside a byte's writable set read 0.
- R3: The lock bit (primary bit 1) behaves as follows:
  - A write that leaves lock set forces open to 0 in the same cycle.
  - Lock stays set until reset.
  - While locked, writes to either control byte leave both bytes unchanged.
- R4: For a non-SMM access in the low legacy window, the route depends on open and high enable:
  - open=1 and high enable=0 routes to DRAM (0).
  - open=1 and high enable=1 routes to PCI (1).
  - open=0 routes to PCI (1).
- R5: For a non-SMM access in the high alias window [0xFEDA0000, 0xFEDC0000), the route is DRAM only when open=1 and high enable=1, and PCI otherwise. Any access in that window drives `dram_addr_o` as the address minus 0xFEDA0000 plus `LEG_BASE`.
- R6: For an SMM access, global enable adds DRAM routes on top of the non-SMM result:
  - With global enable=1 and high enable=0, the low window routes to DRAM.
  - With global enable=1 and high enable=1, the high alias routes to DRAM.
  - Otherwise an SMM access gets the non-SMM route.
- R7: TSEG is active only when TSEG enable and global enable are both 1. Its size code selects the size: 0 gives 1 MiB, 1 gives 2 MiB, 2 gives 8 MiB, and 3 gives `EXT_TSEG_MB` MiB.
- R8: An active TSEG covers [LOW_TOP - size, LOW_TOP). Inside it, non-SMM accesses route to blackhole (2) and SMM accesses route to DRAM (0).
- R9: Writing 0xFFFF to the size word while `EXT_TSEG_MB` is nonzero stores `EXT_TSEG_MB`. Any other value written is stored as written.
- R10: Outside all protected windows, an address below `LOW_TOP` routes to DRAM and passes through unchanged on `dram_addr_o`. Other addresses route to PCI. Writes with select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 primary, 1 extended, 2 size word, 3 none |
| wr_data_i | input | 16 | Write data; the bytes use bits [7:0] |
| acc_addr_i | input | ADDR_W | Access address |
| acc_smm_i | input | 1 | Access is in system-management mode |
| route_o | output | 2 | Route code: 0 DRAM, 1 PCI, 2 blackhole |
| dram_addr_o | output | ADDR_W | DRAM address for the access |
| smram_ctl_o | output | 8 | Primary control byte |
| ext_ctl_o | output | 8 | Extended control byte |
| tseg_word_o | output | 16 | Extended TSEG size word |

## Verification
The bench builds the block with `LOW_TOP` = 0x40000000 and `EXT_TSEG_MB` = 4. The 1 GiB low-memory top places every TSEG boundary at a short, easily checked address. An extended size of 4 MiB differs from the three fixed sizes, so a wrong size-code decode shows up at the base of the region. A nonzero extended size also enables the query replacement in the size word.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_PCI  = 2'd1,
    ROUTE_HOLE = 2'd2
  } route_e;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_EXT  = 2'd1;
  localparam logic [1:0] SEL_WORD = 2'd2;

  // primary control byte
  localparam int CTL_OPEN = 0;
  localparam int CTL_LOCK = 1;
  localparam int CTL_GEN  = 2;
  // extended control byte
  localparam int EXT_TEN  = 0;
  localparam int EXT_SZ   = 1;
  localparam int EXT_HEN  = 3;

  localparam logic [7:0] CTL_WMASK      = 8'h07;
  localparam logic [7:0] CTL_WMASK_LCK  = 8'h00;
  localparam logic [7:0] EXT_WMASK      = 8'h0F;
  localparam logic [7:0] EXT_WMASK_LCK  = 8'h00;
  localparam logic [15:0] TSEG_QUERY    = 16'hFFFF;
endpackage

// File: rtl/smr_regs.sv
module smr_regs
  import smr_pkg::*;
#(
  parameter int EXT_TSEG_MB = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [7:0]  ctl_o,
  output logic [7:0]  ext_o,
  output logic [15:0] word_o
);
  localparam logic [15:0] EXT_WORD = 16'(EXT_TSEG_MB);

  logic [7:0]  ctl_q, ext_q, ctl_nxt, ext_nxt, ctl_m, ext_m;
  logic [15:0] word_q, word_nxt;
  logic        locked;

  assign locked = ctl_q[CTL_LOCK];
  assign ctl_m  = locked ? CTL_WMASK_LCK : CTL_WMASK;
  assign ext_m  = locked ? EXT_WMASK_LCK : EXT_WMASK;

  always_comb begin
    ctl_nxt = (ctl_q & ~ctl_m) | (wr_data_i[7:0] & ctl_m);
    ctl_nxt[CTL_LOCK] = ctl_nxt[CTL_LOCK] | locked;
    if (ctl_nxt[CTL_LOCK]) ctl_nxt[CTL_OPEN] = 1'b0;
    ext_nxt = (ext_q & ~ext_m) | (wr_data_i[7:0] & ext_m);
    if (EXT_TSEG_MB > 0 && wr_data_i == TSEG_QUERY) word_nxt = EXT_WORD;
    else word_nxt = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      ext_q  <= '0;
      word_q <= TSEG_QUERY;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_CTL:  ctl_q  <= ctl_nxt;
        SEL_EXT:  ext_q  <= ext_nxt;
        SEL_WORD: word_q <= word_nxt;
        default: ;
      endcase
    end
  end

  assign ctl_o  = ctl_q;
  assign ext_o  = ext_q;
  assign word_o = word_q;
endmodule

// File: rtl/smr_tseg.sv
module smr_tseg
  import smr_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP   = 32'h8000_0000,
  parameter int              EXT_TSEG_MB = 16
) (
  input  logic [7:0]        ctl_i,
  input  logic [7:0]        ext_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam logic [ADDR_W-1:0] SZ_1M = ADDR_W'(64'd1 << 20);
  localparam logic [ADDR_W-1:0] SZ_2M = ADDR_W'(64'd2 << 20);
  localparam logic [ADDR_W-1:0] SZ_8M = ADDR_W'(64'd8 << 20);

  logic [ADDR_W-1:0] sz_ext, size;

  generate
    if (EXT_TSEG_MB > 0) begin : g_ext
      assign sz_ext = ADDR_W'(64'(EXT_TSEG_MB) << 20);
    end else begin : g_no_ext
      assign sz_ext = '0;
    end
  endgenerate

  always_comb begin
    case (ext_i[EXT_SZ +: 2])
      2'd0:    size = SZ_1M;
      2'd1:    size = SZ_2M;
      2'd2:    size = SZ_8M;
      default: size = sz_ext;
    endcase
  end

  assign active_o = ext_i[EXT_TEN] & ctl_i[CTL_GEN];
  assign base_o   = LOW_TOP - size;
endmodule

// File: rtl/smr_route.sv
module smr_route
  import smr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP   = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] LEG_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              smm_i,
  input  logic [7:0]        ctl_i,
  input  logic [7:0]        ext_i,
  input  logic              tseg_act_i,
  input  logic [ADDR_W-1:0] tseg_base_i,
  output logic [1:0]        route_o,
  output logic [ADDR_W-1:0] dram_addr_o
);
  localparam logic [ADDR_W-1:0] LEG_END  = LEG_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + WIN_SIZE;

  logic in_leg, in_high, in_tseg, open, gen, hen;
  route_e plain, rt;

  assign open    = ctl_i[CTL_OPEN];
  assign gen     = ctl_i[CTL_GEN];
  assign hen     = ext_i[EXT_HEN];
  assign in_leg  = addr_i >= LEG_BASE && addr_i < LEG_END;
  assign in_high = addr_i >= HIGH_BASE && addr_i < HIGH_END;
  assign in_tseg = tseg_act_i && addr_i >= tseg_base_i && addr_i < LOW_TOP;

  // view of a non-SMM agent
  always_comb begin
    if (in_tseg)       plain = ROUTE_HOLE;
    else if (in_leg)   plain = (open && !hen) ? ROUTE_DRAM : ROUTE_PCI;
    else if (in_high)  plain = (open && hen) ? ROUTE_DRAM : ROUTE_PCI;
    else if (addr_i < LOW_TOP) plain = ROUTE_DRAM;
    else               plain = ROUTE_PCI;
  end

  // SMM overlay on top of the plain view
  always_comb begin
    rt = plain;
    if (smm_i) begin
      if (in_tseg)                      rt = ROUTE_DRAM;
      else if (in_leg && gen && !hen)   rt = ROUTE_DRAM;
      else if (in_high && gen && hen)   rt = ROUTE_DRAM;
    end
  end

  assign route_o     = rt;
  assign dram_addr_o = in_high ? (addr_i - HIGH_BASE + LEG_BASE) : addr_i;
endmodule

// File: rtl/smm_route_ctrl.sv
module smm_route_ctrl
  import smr_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP     = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] LEG_BASE    = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE    = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE   = 32'hFEDA_0000,
  parameter int                EXT_TSEG_MB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [15:0]       wr_data_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_smm_i,
  output logic [1:0]        route_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic [7:0]        smram_ctl_o,
  output logic [7:0]        ext_ctl_o,
  output logic [15:0]       tseg_word_o
);
  logic              tseg_act;
  logic [ADDR_W-1:0] tseg_base;

  smr_regs #(.EXT_TSEG_MB(EXT_TSEG_MB)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ctl_o     (smram_ctl_o),
    .ext_o     (ext_ctl_o),
    .word_o    (tseg_word_o)
  );

  smr_tseg #(.ADDR_W(ADDR_W), .LOW_TOP(LOW_TOP), .EXT_TSEG_MB(EXT_TSEG_MB)) i_tseg (
    .ctl_i    (smram_ctl_o),
    .ext_i    (ext_ctl_o),
    .active_o (tseg_act),
    .base_o   (tseg_base)
  );

  smr_route #(
    .ADDR_W(ADDR_W), .LOW_TOP(LOW_TOP), .LEG_BASE(LEG_BASE),
    .WIN_SIZE(WIN_SIZE), .HIGH_BASE(HIGH_BASE)
  ) i_route (
    .addr_i      (acc_addr_i),
    .smm_i       (acc_smm_i),
    .ctl_i       (smram_ctl_o),
    .ext_i       (ext_ctl_o),
    .tseg_act_i  (tseg_act),
    .tseg_base_i (tseg_base),
    .route_o     (route_o),
    .dram_addr_o (dram_addr_o)
  );
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] LOW_TOP     = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] LEG_BASE    = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE    = 32'h0002_0000,
  parameter int                EXT_TSEG_MB = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [15:0]       wr_data_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_smm_i,
  input logic [1:0]        route_o,
  input logic [7:0]        smram_ctl_o,
  input logic [7:0]        ext_ctl_o,
  input logic [15:0]       tseg_word_o
);
  localparam logic [ADDR_W-1:0] TSEG1_BASE = LOW_TOP - ADDR_W'(64'd1 << 20);

  logic in_leg, in_t1m, t1m_on;
  assign in_leg = acc_addr_i >= LEG_BASE && acc_addr_i < LEG_BASE + WIN_SIZE;
  assign in_t1m = acc_addr_i >= TSEG1_BASE && acc_addr_i < LOW_TOP;
  assign t1m_on = ext_ctl_o[0] && ext_ctl_o[2:1] == 2'd0 && smram_ctl_o[2];

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_ctl_o[1] |=> smram_ctl_o[1]);

  assert_lock_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_ctl_o[1] |-> !smram_ctl_o[0]);

  assert_locked_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smram_ctl_o[1] |=> $stable(ext_ctl_o));

  assert_closed_legacy_pci_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_smm_i && !smram_ctl_o[0] && in_leg) |-> route_o == 2'd1);

  assert_tseg_hole_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1m_on && in_t1m && !acc_smm_i) |-> route_o == 2'd2);

  assert_tseg_smm_dram_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1m_on && in_t1m && acc_smm_i) |-> route_o == 2'd0);

  assert_query_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_TSEG_MB > 0 && wr_en_i && wr_sel_i == 2'd2 && wr_data_i == 16'hFFFF)
      |=> tseg_word_o == 16'(EXT_TSEG_MB));
endmodule

bind smm_route_ctrl smr_checker #(
  .ADDR_W(ADDR_W), .LOW_TOP(LOW_TOP), .LEG_BASE(LEG_BASE),
  .WIN_SIZE(WIN_SIZE), .EXT_TSEG_MB(EXT_TSEG_MB)
) i_smr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .acc_addr_i  (acc_addr_i),
  .acc_smm_i   (acc_smm_i),
  .route_o     (route_o),
  .smram_ctl_o (smram_ctl_o),
  .ext_ctl_o   (ext_ctl_o),
  .tseg_word_o (tseg_word_o)
);

// File: tb/test_smm_route_ctrl.sv
`timescale 1ns/1ps
module test_smm_route_ctrl;
  localparam int          AW   = 32;
  localparam logic [31:0] LTOP = 32'h4000_0000;
  localparam int          EXTM = 4;

  localparam int K_ROUTE = 0, K_DADDR = 1, K_CTL = 2, K_EXT = 3, K_WORD = 4;
  localparam logic [1:0] DRAM = 2'd0, PCI = 2'd1, HOLE = 2'd2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [AW-1:0] addr = '0;
  logic smm = 1'b0;
  logic [1:0] route;
  logic [AW-1:0] daddr;
  logic [7:0] ctl, ext;
  logic [15:0] word;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  smm_route_ctrl #(.ADDR_W(AW), .LOW_TOP(LTOP), .EXT_TSEG_MB(EXTM)) i_smm_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .acc_addr_i(addr), .acc_smm_i(smm),
    .route_o(route), .dram_addr_o(daddr), .smram_ctl_o(ctl),
    .ext_ctl_o(ext), .tseg_word_o(word)
  );

  // monitor: compare queued expectations after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_ROUTE: act = 32'(route);
          K_DADDR: act = daddr;
          K_CTL:   act = 32'(ctl);
          K_EXT:   act = 32'(ext);
          default: act = 32'(word);
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_route(input logic [31:0] a, input logic s, input logic [1:0] r, input string tag);
    @(negedge clk);
    addr = a; smm = s;
    sb.push_back('{K_ROUTE, 32'(r), tag});
  endtask

  task automatic exp_daddr(input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    addr = a; smm = 1'b0;
    sb.push_back('{K_DADDR, d, tag});
  endtask

  task automatic exp_regs(input logic [7:0] c, input logic [7:0] e, input logic [15:0] w, input string tag);
    @(negedge clk);
    sb.push_back('{K_CTL, 32'(c), tag});
    sb.push_back('{K_EXT, 32'(e), tag});
    sb.push_back('{K_WORD, 32'(w), tag});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_regs(8'h00, 8'h00, 16'hFFFF, "R1 reset values");
    exp_route(32'h000A_0000, 1'b0, PCI,  "R4 closed legacy");
    exp_route(32'h0000_1000, 1'b0, DRAM, "R10 low memory");
    exp_daddr(32'h0000_1000, 32'h0000_1000, "R10 pass-through address");
    exp_route(32'h5000_0000, 1'b0, PCI,  "R10 above low top");

    // R2 masks
    wr(2'd0, 16'h00F9);
    wr(2'd1, 16'h00F0);
    exp_regs(8'h01, 8'h00, 16'hFFFF, "R2 masked writes");
    wr(2'd1, 16'h00FF);
    exp_regs(8'h01, 8'h0F, 16'hFFFF, "R2 extended mask");
    wr(2'd1, 16'h0000);

    // R4/R5 open, high disabled
    exp_route(32'h000B_FFFF, 1'b0, DRAM, "R4 open low window");
    exp_route(32'hFEDA_0000, 1'b0, PCI,  "R5 high alias hidden");
    wr(2'd1, 16'h0008);
    exp_route(32'h000A_0000, 1'b0, PCI,  "R4 open with high enable");
    exp_route(32'hFEDA_0010, 1'b0, DRAM, "R5 high alias visible");
    exp_daddr(32'hFEDA_0010, 32'h000A_0010, "R5 alias translation");
    exp_route(32'hFEDC_0000, 1'b0, PCI,  "R5 past alias end");

    // R6 SMM view
    exp_route(32'h000A_0000, 1'b1, PCI,  "R6 no global enable");
    wr(2'd0, 16'h0005);
    exp_route(32'hFEDA_0000, 1'b1, DRAM, "R6 smm high alias");
    exp_route(32'h000A_0000, 1'b1, PCI,  "R6 smm low with high enable");
    wr(2'd1, 16'h0000);
    exp_route(32'h000A_0000, 1'b1, DRAM, "R6 smm low window");
    exp_route(32'hFEDA_0000, 1'b1, PCI,  "R6 smm high without high enable");
    wr(2'd0, 16'h0004);
    exp_route(32'h000A_8000, 1'b1, DRAM, "R6 smm low while closed");
    exp_route(32'h000A_8000, 1'b0, PCI,  "R6 non-smm low while closed");

    // R7/R8 TSEG
    wr(2'd1, 16'h0001);
    exp_route(32'h3FF0_0000, 1'b0, HOLE, "R8 1MiB base");
    exp_route(32'h3FEF_FFFF, 1'b0, DRAM, "R8 below base");
    exp_route(32'h3FFF_FFFF, 1'b0, HOLE, "R8 last byte");
    exp_route(32'h4000_0000, 1'b0, PCI,  "R8 low top");
    exp_route(32'h3FF0_0000, 1'b1, DRAM, "R8 smm in tseg");
    wr(2'd1, 16'h0003);
    exp_route(32'h3FE0_0000, 1'b0, HOLE, "R7 2MiB base");
    exp_route(32'h3FDF_FFFF, 1'b0, DRAM, "R7 below 2MiB");
    wr(2'd1, 16'h0005);
    exp_route(32'h3F80_0000, 1'b0, HOLE, "R7 8MiB base");
    exp_route(32'h3F7F_FFFF, 1'b0, DRAM, "R7 below 8MiB");
    wr(2'd1, 16'h0007);
    exp_route(32'h3FC0_0000, 1'b0, HOLE, "R7 extended base");
    exp_route(32'h3FBF_FFFF, 1'b0, DRAM, "R7 below extended");
    wr(2'd0, 16'h0000);
    exp_route(32'h3FC0_0000, 1'b0, DRAM, "R7 tseg off without global enable");

    // R9 size word, R10 unused select
    wr(2'd2, 16'h1234);
    exp_regs(8'h00, 8'h07, 16'h1234, "R9 plain store");
    wr(2'd2, 16'hFFFF);
    exp_regs(8'h00, 8'h07, 16'h0004, "R9 query fill");
    wr(2'd3, 16'h00FF);
    exp_regs(8'h00, 8'h07, 16'h0004, "R10 select 3 ignored");

    // R3 lock
    wr(2'd0, 16'h0005);
    wr(2'd0, 16'h0007);
    exp_regs(8'h06, 8'h07, 16'h0004, "R3 lock closes open");
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'h0000);
    exp_regs(8'h06, 8'h07, 16'h0004, "R3 locked bytes frozen");
    exp_route(32'h3FC0_0000, 1'b0, HOLE, "R3 tseg kept after lock");
    exp_route(32'h000A_0000, 1'b0, PCI,  "R3 closed legacy after lock");

    // reset clears the lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_regs(8'h00, 8'h00, 16'hFFFF, "R1 values after second reset");
    wr(2'd0, 16'h0001);
    exp_regs(8'h01, 8'h00, 16'hFFFF, "R3 lock released by reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule